// File: doc/BRIEF.md
# CAN Controller Initialization and Configuration Lock

This block holds the mode-control bits of a CAN protocol controller and enforces a two-level write lock on its configuration. A halt bit stops message transfer and forces the transmit pin recessive. Software can set it, and so can hardware reset, an uncorrectable message-RAM error flag or a bus-off indication. An unlock bit can change only while the controller is halted, and it drops by itself when the halt bit is cleared. Protected configuration registers in the surrounding controller take writes only while both bits are set. Their write requests pass through this block, which gates them.

Three further bits are written through the same control port: test mode, monitor mode and disable-retransmission. Test and monitor can only be set while the controller is unlocked, but software can clear them at any time. The disable-retransmission bit changes only while unlocked. When the unlock bit becomes 1, the block emits a one-cycle strobe. That strobe presets the timeout counter from its configured period and clears the registers that reset on configuration entry. For as long as the controller is unlocked, the transmit and receive handlers are held idle.

After the halt bit clears, the block watches the sampled receive bits, one per bit-time strobe. Transfers are enabled only after a run of consecutive recessive bits has been seen.

Top module: `can_init_lock`

## Requirements
- R1: After reset, the halt bit is 1. The unlock, test, monitor and disable-retransmission bits are 0, `tx_pin` is 1, and `xfer_en`, `idle_pulse` and `cfg_entry` are 0.
- R2: The control readback `ctl_q` and the write data `ctl_wdata` share one bit layout: bit 0 halt, bit 1 unlock, bit 2 test, bit 3 monitor, bit 4 disable-retransmission. With no hardware source active, a write loads bit 0 into the halt bit at the next edge.
- R3: A high level on `ram_uncorr_err` or `bus_off` sets the halt bit at the next edge. This holds even when the same cycle carries a host write that clears it.
- R4: While the halt bit is 1, `tx_pin` is 1. Otherwise `tx_pin` follows `tx_bit`.
- R5: Setting the halt bit, whether by a hardware source or by a write with test and monitor written as 1, does not change the test, monitor or disable-retransmission bits.
- R6: A write changes the unlock bit only if the halt bit was already 1 before that write. The unlock bit becomes 0 at the same edge at which the halt bit becomes 0.
- R7: `prot_we` equals `prot_we_req` when halt and unlock are both 1, and is all zeros otherwise.
- R8: `cfg_entry` is 1 for exactly the first cycle in which the unlock bit reads 1.
- R9: `handler_hold` equals the unlock bit.
- R10: A write of 1 to test or monitor sets that bit only when halt and unlock are both 1 before the write. A write of 0 clears it in any state.
- R11: The disable-retransmission bit takes the written value only when halt and unlock are both 1 before the write. Writes at other times leave it unchanged.
- R12: While the halt bit is 0, each `bit_tick` cycle counts a recessive `rx_bit` (1) and restarts the count on a dominant `rx_bit` (0). The count is held at zero while halted. `idle_pulse` is 1 for one cycle, the cycle after the tick that completes IDLE_BITS (default 11) consecutive recessive bits.
- R13: `xfer_en` becomes 1 together with `idle_pulse` and stays 1 until the cycle after the halt bit is seen as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data (layout in R2) |
| ram_uncorr_err | input | 1 | Uncorrectable message-RAM error flag |
| bus_off | input | 1 | Bus-off state indication |
| prot_we_req | input | NPROT | Write requests for protected configuration registers |
| tx_bit | input | 1 | Transmit bit from the bit engine |
| rx_bit | input | 1 | Sampled receive bit |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| ctl_q | output | 5 | Control bits readback |
| prot_we | output | NPROT | Gated protected write enables |
| tx_pin | output | 1 | Transmit pin drive |
| handler_hold | output | 1 | Holds the transmit and receive handlers idle |
| cfg_entry | output | 1 | Timeout preset and configuration-entry clear strobe |
| idle_pulse | output | 1 | Bus idle reached |
| xfer_en | output | 1 | Message transfer enabled |

## Verification
The hardest states to reach are the locked states in which test, monitor or disable-retransmission already hold 1. Only there can a set-while-locked be told apart from a clear. The stimulus reaches them by unlocking first, setting all three bits with a write that also drops the unlock bit, and then optionally clearing the halt bit while still writing 1 to test and monitor. Every one of the 32 write values is then applied from five start states. For the idle detector, the bench sweeps recessive run lengths around the threshold, with dominant breaks between runs, and adds ticks sent while halted.

// File: rtl/can_init_lock.sv
module can_init_lock #(
  parameter int IDLE_BITS = 11,
  parameter int NPROT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [4:0]       ctl_wdata,
  input  logic             ram_uncorr_err,
  input  logic             bus_off,
  input  logic [NPROT-1:0] prot_we_req,
  input  logic             tx_bit,
  input  logic             rx_bit,
  input  logic             bit_tick,
  output logic [4:0]       ctl_q,
  output logic [NPROT-1:0] prot_we,
  output logic             tx_pin,
  output logic             handler_hold,
  output logic             cfg_entry,
  output logic             idle_pulse,
  output logic             xfer_en
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(IDLE_BITS);
  localparam logic [CW-1:0] CNT_LAST = CW'(IDLE_BITS - 1);

  logic halt, unlock, test, mon, dar, unlock_d;
  logic [CW-1:0] cnt;

  wire hw_set  = ram_uncorr_err | bus_off;
  wire open_w  = halt & unlock;
  wire halt_n  = hw_set | (ctl_we ? ctl_wdata[0] : halt);
  wire idle_hit = ~halt & bit_tick & rx_bit & (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt     <= 1'b1;
      unlock   <= 1'b0;
      unlock_d <= 1'b0;
      test     <= 1'b0;
      mon      <= 1'b0;
      dar      <= 1'b0;
    end else begin
      halt     <= halt_n;
      unlock_d <= unlock;
      if (!halt_n)
        unlock <= 1'b0;
      else if (ctl_we && halt)
        unlock <= ctl_wdata[1];
      if (ctl_we) begin
        if (!ctl_wdata[2]) test <= 1'b0;
        else if (open_w) test <= 1'b1;
        if (!ctl_wdata[3]) mon <= 1'b0;
        else if (open_w) mon <= 1'b1;
        if (open_w) dar <= ctl_wdata[4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      idle_pulse <= 1'b0;
      xfer_en    <= 1'b0;
    end else begin
      idle_pulse <= idle_hit;
      if (halt)
        xfer_en <= 1'b0;
      else if (idle_hit)
        xfer_en <= 1'b1;
      if (halt)
        cnt <= '0;
      else if (bit_tick) begin
        if (!rx_bit)
          cnt <= '0;
        else if (cnt < CNT_MAX)
          cnt <= cnt + 1'b1;
      end
    end
  end

  assign ctl_q        = {dar, mon, test, unlock, halt};
  assign prot_we      = prot_we_req & {NPROT{open_w}};
  assign tx_pin       = halt | tx_bit;
  assign handler_hold = unlock;
  assign cfg_entry    = unlock & ~unlock_d;
endmodule

// File: rtl/can_init_lock_chk.sv
module can_init_lock_chk #(
  parameter int NPROT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [4:0]       ctl_wdata,
  input logic             ram_uncorr_err,
  input logic             bus_off,
  input logic [NPROT-1:0] prot_we_req,
  input logic             tx_bit,
  input logic             rx_bit,
  input logic             bit_tick,
  input logic [4:0]       ctl_q,
  input logic [NPROT-1:0] prot_we,
  input logic             tx_pin,
  input logic             handler_hold,
  input logic             cfg_entry,
  input logic             idle_pulse,
  input logic             xfer_en
);
  p_unlock_in_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[1] |-> ctl_q[0]);
  p_hw_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_uncorr_err || bus_off) |=> ctl_q[0]);
  p_tx_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[0] |-> tx_pin);
  p_prot_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_we != '0) |-> (ctl_q[0] && ctl_q[1]));
  p_entry_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_entry |-> (ctl_q[1] && !$past(ctl_q[1])));
  p_test_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[2]) |-> $past(ctl_we && ctl_q[0] && ctl_q[1]));
  p_dar_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_q[0] && ctl_q[1]) |=> $stable(ctl_q[4]));
  p_pulse_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |=> !idle_pulse);
  p_run_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[0] |=> !xfer_en);
  p_pulse_run_r13: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |-> xfer_en);
endmodule

bind can_init_lock can_init_lock_chk #(.NPROT(NPROT)) u_chk (.*);

// File: tb/can_init_lock_tb.sv
`timescale 1ns/1ps
module can_init_lock_tb;
  localparam int IDLE = 11;
  localparam int NP = 4;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, ram_uncorr_err = 0, bus_off = 0;
  logic [4:0] ctl_wdata = 0;
  logic [NP-1:0] prot_we_req = 0;
  logic tx_bit = 0, rx_bit = 1, bit_tick = 0;
  logic [4:0] ctl_q;
  logic [NP-1:0] prot_we;
  logic tx_pin, handler_hold, cfg_entry, idle_pulse, xfer_en;

  int checks = 0, failures = 0, cycles = 0;
  logic m_init, m_cce, m_test, m_mon, m_dar, m_run, m_entry, m_pulse;
  int m_cnt;

  always #2 clk = ~clk;

  can_init_lock #(.IDLE_BITS(IDLE), .NPROT(NP)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 R3 halt", ctl_q[0], m_init);
    chk("R6 unlock", ctl_q[1], m_cce);
    chk("R10 R5 test", ctl_q[2], m_test);
    chk("R10 R5 monitor", ctl_q[3], m_mon);
    chk("R11 R5 noretx", ctl_q[4], m_dar);
    chk("R4 tx_pin", tx_pin, m_init ? 1 : tx_bit);
    chk("R7 prot_we", prot_we, (m_init && m_cce) ? prot_we_req : 0);
    chk("R8 cfg_entry", cfg_entry, m_entry);
    chk("R9 handler_hold", handler_hold, m_cce);
    chk("R12 idle_pulse", idle_pulse, m_pulse);
    chk("R13 xfer_en", xfer_en, m_run);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ctl_we = 0; ram_uncorr_err = 0; bus_off = 0; bit_tick = 0;
    @(negedge clk);
    rst_n = 1;
    m_init = 1; m_cce = 0; m_test = 0; m_mon = 0; m_dar = 0;
    m_run = 0; m_entry = 0; m_pulse = 0; m_cnt = 0;
    #1;
    chk("R1 reset ctl_q", ctl_q, 5'b00001);
    chk("R1 reset tx_pin", tx_pin, 1);
    chk("R1 reset outputs", {xfer_en, idle_pulse, cfg_entry}, 0);
  endtask

  task automatic step(input logic we, input logic [4:0] d, input logic ram,
                      input logic bo, input logic tick, input logic rx);
    logic n_init, n_cce, unl, hit;
    int n_cnt;
    @(negedge clk);
    ctl_we = we; ctl_wdata = d; ram_uncorr_err = ram; bus_off = bo;
    bit_tick = tick; rx_bit = rx;
    tx_bit = ~tx_bit;
    prot_we_req = prot_we_req + 1'b1;
    unl = m_init && m_cce;
    n_init = (ram || bo) ? 1 : (we ? d[0] : m_init);
    n_cce = !n_init ? 0 : ((we && m_init) ? d[1] : m_cce);
    hit = !m_init && tick && rx && (m_cnt == IDLE - 1);
    n_cnt = m_init ? 0 : (tick ? (rx ? (m_cnt < IDLE ? m_cnt + 1 : m_cnt) : 0) : m_cnt);
    @(posedge clk);
    #1;
    if (we) begin
      m_test = d[2] ? (unl ? 1'b1 : m_test) : 1'b0;
      m_mon  = d[3] ? (unl ? 1'b1 : m_mon) : 1'b0;
      if (unl) m_dar = d[4];
    end
    m_run = m_init ? 0 : (hit ? 1 : m_run);
    m_entry = n_cce && !m_cce;
    m_pulse = hit;
    m_init = n_init; m_cce = n_cce; m_cnt = n_cnt;
    check_all();
  endtask

  task automatic wr(input logic [4:0] d);
    step(1, d, 0, 0, 0, 1);
  endtask

  task automatic idle1();
    step(0, 0, 0, 0, 0, 1);
  endtask

  task automatic setup(input int s);
    case (s)
      0: wr(5'b00000);
      1: idle1();
      2: wr(5'b00011);
      3: begin wr(5'b00011); wr(5'b11111); wr(5'b11101); end
      default: begin wr(5'b00011); wr(5'b11111); wr(5'b11101); wr(5'b11100); end
    endcase
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int s = 0; s < 5; s++)
      for (int d = 0; d < 32; d++) begin
        do_reset();
        setup(s);
        wr(5'(d));
        idle1();
      end
    for (int h = 1; h < 4; h++)
      for (int s = 0; s < 5; s++) begin
        do_reset();
        setup(s);
        step(1, 5'b11100, h[0], h[1], 0, 1);
        idle1();
        step(0, 0, h[1], h[0], 0, 1);
      end
    do_reset();
    wr(5'b00000);
    for (int n = 0; n < 14; n++) begin
      for (int i = 0; i < n; i++) begin
        step(0, 0, 0, 0, 1, 1);
        idle1();
      end
      step(0, 0, 0, 0, 1, 0);
      idle1();
    end
    for (int i = 0; i < 13; i++) step(0, 0, 0, 0, 1, 1);
    idle1();
    step(0, 0, 0, 1, 0, 1);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 1, 1);
    wr(5'b00000);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 1, 1);
    wr(5'b00001);
    idle1();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule